// File: doc/BRIEF.md
# Flash Operation Busy and Status Engine

This block follows one internally timed flash operation (a byte program, a sector erase or a whole-bank erase) from the start pulse issued by the command decoder to its end. It counts a parameterised number of clock cycles that depends on the kind of operation. While that count runs, it replaces two bits of every read of the flash bank with status information. One bit is a polling bit that shows the inverted data being programmed, or zero during an erase. The other is a toggle bit that flips on every read strobe.

When the count expires, the block emits a one-cycle completion pulse in the same cycle that busy drops. It then keeps the toggle bit frozen for a short settle window. During that window the polling bit already shows true data, while the rest of the byte is still settling. Outside busy and the settle window, the read bus carries the array data unchanged. Host software can therefore use either polling method to detect the end of a write. The cycle counts are parameters, so a bench can shorten them.

Top module: `flash_busy_status`

## Requirements
- R1: A start pulse accepted while idle raises busy from the very next cycle, so status reads are valid immediately after the final command write.
- R2: Busy stays high for exactly PROG_CYC, SECT_CYC or BANK_CYC cycles, according to the operation that was started.
- R3: The done pulse lasts one cycle and appears at the same clock edge at which busy falls.
- R4: Start pulses that arrive while busy are ignored. When several start pulses arrive together, bank erase wins over sector erase, and sector erase wins over program.
- R5: During a program, bit POLL_BIT (default 7) of the read bus is the complement of the most significant bit of the byte being programmed, as latched at start.
- R6: During either erase, bit POLL_BIT of the read bus is 0.
- R7: While busy, bit TGL_BIT (default 6) shows a toggle flip-flop. The flop inverts after every cycle in which both rd_stb and busy are high, and holds in cycles without rd_stb.
- R8: While busy, all read bits other than POLL_BIT and TGL_BIT pass the array data through.
- R9: For SETTLE_CYC cycles after completion, bit TGL_BIT stays at the frozen toggle value, while every other bit, bit POLL_BIT included, shows array data.
- R10: When the block is idle and outside the settle window, the read bus equals arr_rdata.
- R11: Reset clears busy, done, the settle window and the toggle flop to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_prog | input | 1 | Start pulse for a byte program |
| start_sect | input | 1 | Start pulse for a sector erase |
| start_bank | input | 1 | Start pulse for a bank erase |
| prog_msb | input | 1 | Most significant bit of the byte to be programmed, valid with start_prog |
| rd_stb | input | 1 | Read strobe to the flash bank |
| arr_rdata | input | DATA_W | Array read data |
| busy | output | 1 | Internal operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Read data after status substitution |

## Verification
A wrong count or a lost operation kind shows at busy and done within one operation length: a short count ends early, and the wrong kind selects a different duration and flips the polling bit. A toggle flop that moves on idle cycles, or that misses a strobe, shows on the toggle bit at the next read. A settle counter that is off by one exposes the frozen toggle bit one cycle too long or too short after done. A long pseudo-random stream of starts, strobes and array values is compared cycle by cycle against an arithmetic model, so each of these faults surfaces within a few cycles of its cause.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

   typedef enum logic [1:0] {
      OP_PROG = 2'd0,
      OP_SECT = 2'd1,
      OP_BANK = 2'd2
   } fbs_op_e;

   function automatic int unsigned fbs_max3(input int unsigned a, input int unsigned b,
                                           input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/fbs_op_timer.sv
module fbs_op_timer
   import fbs_pkg::*;
#(
   parameter int unsigned PROG_CYC  = 1000,
   parameter int unsigned SECT_CYC  = 1250000,
   parameter int unsigned BANK_CYC  = 5000000
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    start_prog,
   input  logic    start_sect,
   input  logic    start_bank,
   input  logic    prog_msb,
   output logic    busy,
   output logic    done,
   output logic    fin,
   output fbs_op_e op_kind,
   output logic    msb_q
);

   localparam int unsigned MAX_CYC = fbs_max3(PROG_CYC, SECT_CYC, BANK_CYC);
   localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
   localparam logic [CNT_W-1:0] LD_PROG = CNT_W'(PROG_CYC - 1);
   localparam logic [CNT_W-1:0] LD_SECT = CNT_W'(SECT_CYC - 1);
   localparam logic [CNT_W-1:0] LD_BANK = CNT_W'(BANK_CYC - 1);

   if (PROG_CYC < 1 || SECT_CYC < 1 || BANK_CYC < 1) begin : g_bad_cyc
      $error("fbs_op_timer: every operation needs at least one cycle");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;
   fbs_op_e          sel_op;
   logic             any_start;

   assign any_start = start_prog | start_sect | start_bank;
   assign fin       = busy & (cnt_q == '0);

   // erase kinds dominate, bank first
   always_comb begin
      if (start_bank) begin
         sel_op   = OP_BANK;
         load_val = LD_BANK;
      end else if (start_sect) begin
         sel_op   = OP_SECT;
         load_val = LD_SECT;
      end else begin
         sel_op   = OP_PROG;
         load_val = LD_PROG;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         cnt_q   <= '0;
         op_kind <= OP_PROG;
         msb_q   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (busy) begin
            if (cnt_q == '0) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end else if (any_start) begin
            busy    <= 1'b1;
            cnt_q   <= load_val;
            op_kind <= sel_op;
            msb_q   <= prog_msb;
         end
      end
   end

endmodule

// File: rtl/fbs_toggle.sv
module fbs_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic rd_stb,
   output logic tgl
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgl <= 1'b0;
      end else if (busy && rd_stb) begin
         tgl <= ~tgl;
      end
   end

endmodule

// File: rtl/fbs_settle.sv
module fbs_settle #(
   parameter int unsigned SETTLE_CYC = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fin,
   output logic settle
);

   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("fbs_settle: SETTLE_CYC must be at least 1");
   end

   if (SETTLE_CYC == 1) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) settle <= 1'b0;
         else        settle <= fin;
      end
   end else begin : g_count
      localparam int unsigned SW = $clog2(SETTLE_CYC + 1);
      localparam logic [SW-1:0] LD = SW'(SETTLE_CYC);
      logic [SW-1:0] scnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scnt_q <= '0;
         end else if (fin) begin
            scnt_q <= LD;
         end else if (scnt_q != '0) begin
            scnt_q <= scnt_q - 1'b1;
         end
      end

      assign settle = (scnt_q != '0);
   end

endmodule

// File: rtl/fbs_status_mux.sv
module fbs_status_mux #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned POLL_BIT = 7,
   parameter int unsigned TGL_BIT  = 6
) (
   input  logic              busy,
   input  logic              is_erase,
   input  logic              msb_q,
   input  logic              tgl,
   input  logic              settle,
   input  logic [DATA_W-1:0] arr_rdata,
   output logic [DATA_W-1:0] rdata
);

   if (POLL_BIT >= DATA_W || TGL_BIT >= DATA_W || POLL_BIT == TGL_BIT) begin : g_bad_bits
      $error("fbs_status_mux: status bit positions invalid");
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i == POLL_BIT) begin : g_poll
         assign rdata[i] = busy ? (~is_erase & ~msb_q) : arr_rdata[i];
      end else if (i == TGL_BIT) begin : g_tgl
         assign rdata[i] = (busy | settle) ? tgl : arr_rdata[i];
      end else begin : g_pass
         assign rdata[i] = arr_rdata[i];
      end
   end

endmodule

// File: rtl/flash_busy_status.sv
module flash_busy_status
   import fbs_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned POLL_BIT   = 7,
   parameter int unsigned TGL_BIT    = 6,
   parameter int unsigned PROG_CYC   = 1000,
   parameter int unsigned SECT_CYC   = 1250000,
   parameter int unsigned BANK_CYC   = 5000000,
   parameter int unsigned SETTLE_CYC = 50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_prog,
   input  logic              start_sect,
   input  logic              start_bank,
   input  logic              prog_msb,
   input  logic              rd_stb,
   input  logic [DATA_W-1:0] arr_rdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata
);

   fbs_op_e op_kind;
   logic    msb_q;
   logic    fin;
   logic    tgl;
   logic    settle;

   fbs_op_timer #(
      .PROG_CYC (PROG_CYC),
      .SECT_CYC (SECT_CYC),
      .BANK_CYC (BANK_CYC)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_prog (start_prog),
      .start_sect (start_sect),
      .start_bank (start_bank),
      .prog_msb   (prog_msb),
      .busy       (busy),
      .done       (done),
      .fin        (fin),
      .op_kind    (op_kind),
      .msb_q      (msb_q)
   );

   fbs_toggle u_toggle (
      .clk    (clk),
      .rst_n  (rst_n),
      .busy   (busy),
      .rd_stb (rd_stb),
      .tgl    (tgl)
   );

   fbs_settle #(
      .SETTLE_CYC (SETTLE_CYC)
   ) u_settle (
      .clk    (clk),
      .rst_n  (rst_n),
      .fin    (fin),
      .settle (settle)
   );

   fbs_status_mux #(
      .DATA_W   (DATA_W),
      .POLL_BIT (POLL_BIT),
      .TGL_BIT  (TGL_BIT)
   ) u_mux (
      .busy      (busy),
      .is_erase  (op_kind != OP_PROG),
      .msb_q     (msb_q),
      .tgl       (tgl),
      .settle    (settle),
      .arr_rdata (arr_rdata),
      .rdata     (rdata)
   );

endmodule

// File: rtl/fbs_chk.sv
module fbs_chk
   import fbs_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned POLL_BIT   = 7,
   parameter int unsigned TGL_BIT    = 6,
   parameter int unsigned PROG_CYC   = 1000,
   parameter int unsigned SECT_CYC   = 1250000,
   parameter int unsigned BANK_CYC   = 5000000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_prog,
   input logic              start_sect,
   input logic              start_bank,
   input logic              rd_stb,
   input logic [DATA_W-1:0] arr_rdata,
   input logic              busy,
   input logic              done,
   input logic [DATA_W-1:0] rdata,
   input fbs_op_e           op_kind,
   input logic              msb_q,
   input logic              settle
);

   localparam int unsigned MAX_CYC = fbs_max3(PROG_CYC, SECT_CYC, BANK_CYC);
   localparam int unsigned BW      = $clog2(MAX_CYC + 2);

   logic [BW-1:0] bcnt;
   logic [BW-1:0] exp_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bcnt <= '0;
      else if (busy) bcnt <= bcnt + 1'b1;
      else           bcnt <= '0;
   end

   always_comb begin
      case (op_kind)
         OP_BANK: exp_len = BW'(BANK_CYC);
         OP_SECT: exp_len = BW'(SECT_CYC);
         default: exp_len = BW'(PROG_CYC);
      endcase
   end

   a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (start_prog || start_sect || start_bank)) |=> busy);

   a_r2_duration: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (bcnt == exp_len));

   a_r3_done_edge: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r5_prog_poll: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_kind == OP_PROG) |-> (rdata[POLL_BIT] != msb_q));

   a_r6_erase_poll: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_kind != OP_PROG) |-> (rdata[POLL_BIT] == 1'b0));

   a_r7_toggle_read: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_stb) |=> (!busy || rdata[TGL_BIT] != $past(rdata[TGL_BIT])));

   a_r7_toggle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rd_stb) |=> (!busy || rdata[TGL_BIT] == $past(rdata[TGL_BIT])));

   a_r10_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !settle) |-> (rdata == arr_rdata));

endmodule

bind flash_busy_status fbs_chk #(
   .DATA_W   (DATA_W),
   .POLL_BIT (POLL_BIT),
   .TGL_BIT  (TGL_BIT),
   .PROG_CYC (PROG_CYC),
   .SECT_CYC (SECT_CYC),
   .BANK_CYC (BANK_CYC)
) u_fbs_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_prog (start_prog),
   .start_sect (start_sect),
   .start_bank (start_bank),
   .rd_stb     (rd_stb),
   .arr_rdata  (arr_rdata),
   .busy       (busy),
   .done       (done),
   .rdata      (rdata),
   .op_kind    (op_kind),
   .msb_q      (msb_q),
   .settle     (settle)
);

// File: tb/test_flash_busy_status.sv
`timescale 1ns/1ps
module test_flash_busy_status;

   localparam int P_CYC = 5;
   localparam int S_CYC = 9;
   localparam int B_CYC = 13;
   localparam int SET_C = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_prog = 1'b0, start_sect = 1'b0, start_bank = 1'b0;
   logic       prog_msb = 1'b0, rd_stb = 1'b0;
   logic [7:0] arr_rdata = 8'h00;
   logic       busy, done;
   logic [7:0] rdata;

   int nchk = 0;
   int nfail = 0;
   int ncyc = 0;

   // bench-side reference state
   logic m_busy = 1'b0, m_done = 1'b0, m_tgl = 1'b0, m_msb = 1'b0;
   int   m_kind = 0, m_cnt = 0, m_settle = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #10 clk = ~clk;

   flash_busy_status #(
      .PROG_CYC (P_CYC), .SECT_CYC (S_CYC), .BANK_CYC (B_CYC), .SETTLE_CYC (SET_C)
   ) i_flash_busy_status (
      .clk (clk), .rst_n (rst_n),
      .start_prog (start_prog), .start_sect (start_sect), .start_bank (start_bank),
      .prog_msb (prog_msb), .rd_stb (rd_stb), .arr_rdata (arr_rdata),
      .busy (busy), .done (done), .rdata (rdata)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, ncyc);
      end
   endtask

   function automatic int dur(input int k);
      return (k == 2) ? B_CYC : (k == 1) ? S_CYC : P_CYC;
   endfunction

   task automatic step(input logic sp, input logic ss, input logic sb, input logic pm,
                       input logic rs, input logic [7:0] ad);
      logic [7:0] exp;
      @(negedge clk);
      start_prog = sp; start_sect = ss; start_bank = sb;
      prog_msb = pm; rd_stb = rs; arr_rdata = ad;
      #2;
      exp = ad;
      if (m_busy) begin
         exp[7] = (m_kind == 0) ? ~m_msb : 1'b0;
         exp[6] = m_tgl;
      end else if (m_settle > 0) begin
         exp[6] = m_tgl;
      end
      chk((m_busy && m_cnt == dur(m_kind)) ? "R1" : "R2", {7'd0, busy}, {7'd0, m_busy});
      chk("R3", {7'd0, done}, {7'd0, m_done});
      chk(m_busy ? ((m_kind == 0) ? "R5" : "R6") : "R10", {7'd0, rdata[7]}, {7'd0, exp[7]});
      chk(m_busy ? "R7" : ((m_settle > 0) ? "R9" : "R10"), {7'd0, rdata[6]}, {7'd0, exp[6]});
      chk("R8", {2'd0, rdata[5:0]}, {2'd0, exp[5:0]});
      @(posedge clk);
      ncyc++;
      // model update; R4 start ignored while busy, bank > sector > program
      m_done = 1'b0;
      if (m_busy && rs) m_tgl = ~m_tgl;
      if (m_busy && m_cnt == 1) m_settle = SET_C;
      else if (m_settle > 0) m_settle--;
      if (m_busy) begin
         if (m_cnt == 1) begin
            m_busy = 1'b0;
            m_done = 1'b1;
         end else begin
            m_cnt--;
         end
      end else if (sp || ss || sb) begin
         m_busy = 1'b1;
         m_kind = sb ? 2 : (ss ? 1 : 0);
         m_cnt  = dur(m_kind);
         m_msb  = pm;
      end
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R11: reset state, idle reads pass through
      step(0, 0, 0, 0, 1, 8'hA5);
      step(0, 0, 0, 0, 0, 8'h5A);

      // sweep of each kind, both data polarities, several read rates
      for (int op = 0; op < 3; op++) begin
         for (int d = 0; d < 6; d++) begin
            step(op == 0, op == 1, op == 2, d[0], d[1], 8'(d * 37 + op));
            for (int k = 0; k < B_CYC + SET_C + 1; k++) begin
               // R4: a late different start must be ignored
               step(k == 2 && op != 2, k == 3, k == 4 && op != 0, ~d[0],
                    (k % (d % 4 + 1)) == 0, 8'(k * 29 + d * 7 + 3));
            end
            for (int g = 0; g < d % 3; g++) step(0, 0, 0, 0, 1, 8'(g + 8'hC0));
         end
      end

      // R4: simultaneous starts
      step(1, 1, 1, 1, 0, 8'h11);
      for (int k = 0; k < B_CYC + 3; k++) step(0, 0, 0, 0, k[0], 8'(k + 8'h40));
      step(1, 1, 0, 0, 0, 8'h22);
      for (int k = 0; k < S_CYC + 3; k++) step(0, 0, 0, 0, 1, 8'(k + 8'h60));

      // back-to-back: restart right when done shows
      step(1, 0, 0, 1, 1, 8'h33);
      for (int k = 0; k < P_CYC; k++) step(0, 0, 0, 0, 1, 8'hF0);
      step(0, 1, 0, 0, 1, 8'h0F);
      for (int k = 0; k < S_CYC + 3; k++) step(0, 0, 0, 0, 0, 8'(k));

      // pseudo-random stream
      for (int n = 0; n < 1500; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[3:0] == 4'h1, lfsr[3:0] == 4'h2, lfsr[3:0] == 4'h3,
              lfsr[9], lfsr[5], lfsr[15:8] ^ lfsr[7:0]);
      end

      summary();
   end

endmodule